// File: doc/BRIEF.md
# Circuit-Switch Path Controller

This block runs one node's share of a bufferless circuit that carries a packet from a sensor node toward the base node. A node-to-base request arrives on one of the node's ports with a hop count. The controller compares that count against two per-node limits, a maximum and a threshold, and then does one of two things. It can extend the circuit: it answers the upstream node with a Wait, forwards the request with the hop count raised by one toward its near-node port, and then drives a port-to-port switch. Or it can fall back to store-and-forward: it tells the local packet buffer to take the packet in. When both limits are set to 1, every request is taken into the buffer, so the node acts as a plain packet switch.

Once the circuit is extended, the switch is enabled in the reverse direction (base side toward originator). In this direction the base node's clear-to-send can travel back through it. The clear-to-send turns the switch to the forward direction so the data can pass. The end of the data turns it back to reverse for the acknowledgement. The end of the acknowledgement releases the switch. If no clear-to-send arrives within a programmable number of cycles, the switch is released anyway.

A busy mask marks the two ports the circuit holds, so that other logic keeps off them.

States:
- `S_IDLE`: free.
- `S_ANNOUNCE`: one cycle; sends the Wait and the forwarded request.
- `S_HOLD`: switch enabled in reverse; waiting for clear-to-send.
- `S_DATA`: switch forward.
- `S_ACK`: switch reverse.
- `S_TAKE`: one cycle; buffer takes the packet.

Transitions:
- `S_IDLE` to `S_ANNOUNCE` on an extending request.
- `S_IDLE` to `S_TAKE` on a falling-back request.
- `S_TAKE` to `S_IDLE` after one cycle.
- `S_ANNOUNCE` to `S_HOLD` after one cycle.
- `S_HOLD` to `S_DATA` on clear-to-send.
- `S_HOLD` to `S_IDLE` on timeout.
- `S_DATA` to `S_ACK` on data end.
- `S_ACK` to `S_IDLE` on acknowledgement end.

Top module: `cs_path_ctrl`

## Requirements
- R1: After reset all outputs are low: `sw_en`, `wait_send`, `fwd_send`, `take_pkt` and `busy_ports` are 0.
- R2: A request in `S_IDLE` with hop count below the threshold and below the maximum extends the circuit. One cycle later `wait_send` and `fwd_send` are 1 for exactly one cycle, and `fwd_hops` equals the received count plus one. This holds whatever `near_busy` is.
- R3: A request whose hop count is greater than or equal to `cfg_max_hops` raises `take_pkt` for one cycle, one cycle later. It sends no Wait, does not forward, and leaves `sw_en` at 0.
- R4: A request whose hop count is at least `cfg_thresh` but below `cfg_max_hops` is taken (`take_pkt`) when `near_busy` is 1 and extended (R2) when `near_busy` is 0.
- R5: With `cfg_max_hops` and `cfg_thresh` both 1, a request with hop count 1 is always taken, whatever `near_busy` is.
- R6: The cycle after the announce, `sw_en` is 1 and `sw_dir` is 1 (reverse: base side toward originator). `sw_up_port` is the port the request came in on, and `sw_dn_port` is the near-node port. This holds until clear-to-send.
- R7: A `cts_in` pulse in `S_HOLD` makes `sw_dir` 0 (forward: originator toward base) from the next cycle until `data_end`.
- R8: A `data_end` pulse in `S_DATA` sets `sw_dir` to 1 from the next cycle. A following `ack_end` pulse clears `sw_en` and `busy_ports` from the next cycle.
- R9: If no `cts_in` arrives, `sw_en` stays 1 for exactly `cfg_timeout` cycles of `S_HOLD` and then falls to 0 (timeout of at least 1).
- R10: From the announce cycle until release, `busy_ports` has bit `sw_up_port` and bit `sw_dn_port` set and no other bit (bit i stands for port i).
- R11: A request that arrives while the controller is not in `S_IDLE` is ignored. It raises neither `wait_send` nor `take_pkt`, and the switch keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle pulse: node-to-base request received |
| req_hops | input | HOP_W | Hop count carried in the request |
| req_port | input | PORT_W | Port on which the request arrived |
| near_busy | input | 1 | Near-node currently busy |
| cts_in | input | 1 | Clear-to-send from the base side (pulse) |
| data_end | input | 1 | End of the data packet (pulse) |
| ack_end | input | 1 | End of the acknowledgement (pulse) |
| cfg_max_hops | input | HOP_W | Maximum hop-count limit |
| cfg_thresh | input | HOP_W | Hop-count threshold |
| cfg_near_port | input | PORT_W | Port toward the near-node |
| cfg_timeout | input | TO_W | Cycles to wait for clear-to-send |
| wait_send | output | 1 | Send Wait upstream |
| fwd_send | output | 1 | Forward the request toward the near-node |
| fwd_hops | output | HOP_W | Hop count for the forwarded request |
| sw_en | output | 1 | Switch connected |
| sw_dir | output | 1 | 0 forward, 1 reverse |
| sw_up_port | output | PORT_W | Upstream switch port |
| sw_dn_port | output | PORT_W | Downstream switch port |
| take_pkt | output | 1 | Buffer takes the packet (store-and-forward) |
| busy_ports | output | NPORTS | Ports held by the circuit |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- **Request decision** (`wait_send`, `fwd_send`, `fwd_hops` or `take_pkt`): one cycle after the request pulse.
- **Switch enable in reverse**: the cycle after the announce.
- **Direction changes**: one cycle after the `cts_in` or `data_end` pulse.
- **Release**: one cycle after `ack_end`.
- **Timeout release**: after exactly `cfg_timeout` cycles of `S_HOLD`.

The bench drives inputs at the falling edge and samples at the next falling edge. One registered step therefore lands on exactly one sample, and the checks count samples to reach the due cycle.

// File: rtl/cs_path_pkg.sv
package cs_path_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ANNOUNCE,
        S_HOLD,
        S_DATA,
        S_ACK,
        S_TAKE
    } cs_state_e;

    localparam logic DIR_FWD = 1'b0;
    localparam logic DIR_REV = 1'b1;
endpackage

// File: rtl/cs_hop_judge.sv
module cs_hop_judge #(
    parameter int HOP_W = 4
) (
    input  logic [HOP_W-1:0] hops,
    input  logic [HOP_W-1:0] max_hops,
    input  logic [HOP_W-1:0] thresh,
    input  logic             near_busy,
    output logic             extend
);
    logic at_max;
    logic at_thr;

    always_comb begin
        at_max = (hops >= max_hops);
        at_thr = (hops >= thresh);
        extend = !at_max && !(at_thr && near_busy);
    end
endmodule

// File: rtl/cs_cts_timer.sv
module cs_cts_timer #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign expired = run && (cnt == limit - 1'b1);

    // R9: while waiting, the count never passes the programmed window
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/cs_path_ctrl.sv
module cs_path_ctrl
    import cs_path_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int HOP_W  = 4,
    parameter int TO_W   = 8,
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [HOP_W-1:0]  req_hops,
    input  logic [PORT_W-1:0] req_port,
    input  logic              near_busy,
    input  logic              cts_in,
    input  logic              data_end,
    input  logic              ack_end,
    input  logic [HOP_W-1:0]  cfg_max_hops,
    input  logic [HOP_W-1:0]  cfg_thresh,
    input  logic [PORT_W-1:0] cfg_near_port,
    input  logic [TO_W-1:0]   cfg_timeout,
    output logic              wait_send,
    output logic              fwd_send,
    output logic [HOP_W-1:0]  fwd_hops,
    output logic              sw_en,
    output logic              sw_dir,
    output logic [PORT_W-1:0] sw_up_port,
    output logic [PORT_W-1:0] sw_dn_port,
    output logic              take_pkt,
    output logic [NPORTS-1:0] busy_ports
);
    cs_state_e         state_q, state_d;
    logic [HOP_W-1:0]  hop_q;
    logic [PORT_W-1:0] up_q, dn_q;
    logic              extend;
    logic              expired;
    logic              holding;

    cs_hop_judge #(.HOP_W(HOP_W)) u_judge (
        .hops      (req_hops),
        .max_hops  (cfg_max_hops),
        .thresh    (cfg_thresh),
        .near_busy (near_busy),
        .extend    (extend)
    );

    cs_cts_timer #(.TO_W(TO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == S_HOLD),
        .limit   (cfg_timeout),
        .expired (expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = extend ? S_ANNOUNCE : S_TAKE;
            S_ANNOUNCE: state_d = S_HOLD;
            S_HOLD:     if (cts_in) state_d = S_DATA;
                        else if (expired) state_d = S_IDLE;
            S_DATA:     if (data_end) state_d = S_ACK;
            S_ACK:      if (ack_end) state_d = S_IDLE;
            S_TAKE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hop_q   <= '0;
            up_q    <= '0;
            dn_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                hop_q <= req_hops + 1'b1;
                up_q  <= req_port;
                dn_q  <= cfg_near_port;
            end
        end
    end

    always_comb begin
        wait_send = 1'b0;
        fwd_send  = 1'b0;
        take_pkt  = 1'b0;
        sw_en     = 1'b0;
        sw_dir    = DIR_REV;
        holding   = 1'b0;
        unique case (state_q)
            S_IDLE:     ;
            S_ANNOUNCE: begin wait_send = 1'b1; fwd_send = 1'b1; holding = 1'b1; end
            S_HOLD:     begin sw_en = 1'b1; sw_dir = DIR_REV; holding = 1'b1; end
            S_DATA:     begin sw_en = 1'b1; sw_dir = DIR_FWD; holding = 1'b1; end
            S_ACK:      begin sw_en = 1'b1; sw_dir = DIR_REV; holding = 1'b1; end
            S_TAKE:     take_pkt = 1'b1;
            default:    ;
        endcase
    end

    assign fwd_hops   = hop_q;
    assign sw_up_port = up_q;
    assign sw_dn_port = dn_q;

    for (genvar g = 0; g < NPORTS; g++) begin : g_busy
        assign busy_ports[g] = holding && (up_q == PORT_W'(g) || dn_q == PORT_W'(g));
    end

    // R6: announce is followed by the reverse-connected switch
    p_hold_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wait_send |=> (sw_en && sw_dir == DIR_REV));
    // R2: forwarded count is the received count plus one
    p_fwd_hops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_send |-> (fwd_hops == HOP_W'($past(req_hops) + 1'b1)));
    // R3: taking the packet never coexists with circuit activity
    p_take_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_pkt |-> (!wait_send && !fwd_send && !sw_en));
    // R7: forward direction only after a clear-to-send or while already forward
    p_fwd_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && sw_dir == DIR_FWD) |->
            ($past(cts_in) || ($past(sw_en) && $past(sw_dir) == DIR_FWD)));
    // R10: the upstream port is marked busy while connected
    p_busy_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> (busy_ports[sw_up_port] && $countones(busy_ports) <= 2));
    // R11: a request during an active circuit raises nothing
    p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sw_en) |=> (!wait_send && !take_pkt));
endmodule

// File: tb/cs_path_ctrl_tb.sv
`timescale 1ns/1ps
module cs_path_ctrl_tb;
    localparam int NPORTS = 4;
    localparam int HOP_W  = 4;
    localparam int TO_W   = 8;
    localparam int PORT_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [HOP_W-1:0] req_hops = '0;
    logic [PORT_W-1:0] req_port = '0;
    logic near_busy = 1'b0, cts_in = 1'b0, data_end = 1'b0, ack_end = 1'b0;
    logic [HOP_W-1:0] cfg_max_hops = 4'd8, cfg_thresh = 4'd4;
    logic [PORT_W-1:0] cfg_near_port = 2'd0;
    logic [TO_W-1:0] cfg_timeout = 8'd2;
    logic wait_send, fwd_send, sw_en, sw_dir, take_pkt;
    logic [HOP_W-1:0] fwd_hops;
    logic [PORT_W-1:0] sw_up_port, sw_dn_port;
    logic [NPORTS-1:0] busy_ports;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    cs_path_ctrl #(.NPORTS(NPORTS), .HOP_W(HOP_W), .TO_W(TO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hops(req_hops),
        .req_port(req_port), .near_busy(near_busy), .cts_in(cts_in),
        .data_end(data_end), .ack_end(ack_end), .cfg_max_hops(cfg_max_hops),
        .cfg_thresh(cfg_thresh), .cfg_near_port(cfg_near_port),
        .cfg_timeout(cfg_timeout), .wait_send(wait_send), .fwd_send(fwd_send),
        .fwd_hops(fwd_hops), .sw_en(sw_en), .sw_dir(sw_dir),
        .sw_up_port(sw_up_port), .sw_dn_port(sw_dn_port), .take_pkt(take_pkt),
        .busy_ports(busy_ports)
    );

    // {max[13:10], thresh[9:6], near_busy[5], hops[4:1], expect_extend[0]}
    localparam logic [13:0] VEC [8] = '{
        {4'd8, 4'd4, 1'b0, 4'd1,  1'b1},   // R2 below threshold
        {4'd8, 4'd4, 1'b0, 4'd4,  1'b1},   // R4 at threshold, near free
        {4'd8, 4'd4, 1'b1, 4'd4,  1'b0},   // R4 at threshold, near busy
        {4'd8, 4'd4, 1'b1, 4'd3,  1'b1},   // R2 below threshold, busy ignored
        {4'd8, 4'd4, 1'b0, 4'd8,  1'b0},   // R3 at maximum
        {4'd8, 4'd4, 1'b0, 4'd12, 1'b0},   // R3 above maximum
        {4'd1, 4'd1, 1'b0, 4'd1,  1'b0},   // R5 pure packet
        {4'd1, 4'd1, 1'b1, 4'd1,  1'b0}    // R5 pure packet, busy
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input logic [HOP_W-1:0] h, input logic [PORT_W-1:0] p);
        req_hops = h; req_port = p; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 sw_en", sw_en, 0);
        chk("R1 busy", busy_ports, 0);
        chk("R1 pulses", {wait_send, fwd_send, take_pkt}, 0);
        rst_n = 1'b1;
        step(1);

        // table of decisions
        cfg_timeout = 8'd2;
        for (int i = 0; i < 8; i++) begin
            cfg_max_hops = VEC[i][13:10];
            cfg_thresh   = VEC[i][9:6];
            near_busy    = VEC[i][5];
            pulse_req(VEC[i][4:1], 2'd1);
            chk("R2/R3/R4/R5 wait", wait_send, VEC[i][0]);
            chk("R2 fwd", fwd_send, VEC[i][0]);
            chk("R3 take", take_pkt, !VEC[i][0]);
            if (VEC[i][0]) chk("R2 fwd_hops", fwd_hops, VEC[i][4:1] + 4'd1);
            else chk("R3 sw_en", sw_en, 0);
            step(5);
            chk("R9 back idle", sw_en, 0);
        end

        // full circuit sequence
        cfg_max_hops = 4'd8; cfg_thresh = 4'd4; near_busy = 1'b0;
        cfg_near_port = 2'd0; cfg_timeout = 8'd20;
        pulse_req(4'd2, 2'd2);
        chk("R2 wait one", wait_send, 1);
        chk("R2 hops", fwd_hops, 4'd3);
        chk("R10 busy announce", busy_ports, 4'b0101);
        step(1);
        chk("R2 wait single cycle", wait_send, 0);
        chk("R6 sw_en", sw_en, 1);
        chk("R6 dir rev", sw_dir, 1);
        chk("R6 up port", sw_up_port, 2'd2);
        chk("R6 dn port", sw_dn_port, 2'd0);
        chk("R10 busy hold", busy_ports, 4'b0101);
        // R11 request during hold ignored
        near_busy = 1'b1;
        pulse_req(4'd9, 2'd3);
        chk("R11 no wait", wait_send, 0);
        chk("R11 no take", take_pkt, 0);
        chk("R11 switch kept", {sw_en, sw_dir, sw_up_port}, {1'b1, 1'b1, 2'd2});
        near_busy = 1'b0;
        // R7 clear-to-send
        cts_in = 1'b1; step(1); cts_in = 1'b0;
        chk("R7 dir fwd", sw_dir, 0);
        step(3);
        chk("R7 dir held", {sw_en, sw_dir}, 2'b10);
        // R8 data end and ack end
        data_end = 1'b1; step(1); data_end = 1'b0;
        chk("R8 dir rev", {sw_en, sw_dir}, 2'b11);
        step(2);
        ack_end = 1'b1; step(1); ack_end = 1'b0;
        chk("R8 released", sw_en, 0);
        chk("R8 busy cleared", busy_ports, 0);

        // R9 timeout window of 3 cycles
        cfg_timeout = 8'd3; cfg_near_port = 2'd3;
        pulse_req(4'd1, 2'd0);
        chk("R9 announce", wait_send, 1);
        step(1); chk("R9 hold c1", sw_en, 1);
        step(1); chk("R9 hold c2", sw_en, 1);
        step(1); chk("R9 hold c3", sw_en, 1);
        step(1); chk("R9 expired", sw_en, 0);
        chk("R9 busy cleared", busy_ports, 0);

        // R11 request during ack phase
        cfg_timeout = 8'd20;
        pulse_req(4'd1, 2'd1);
        step(1);
        cts_in = 1'b1; step(1); cts_in = 1'b0;
        data_end = 1'b1; step(1); data_end = 1'b0;
        pulse_req(4'd15, 2'd2);
        chk("R11 ack no take", take_pkt, 0);
        chk("R11 ack kept", {sw_en, sw_dir, sw_up_port}, {1'b1, 1'b1, 2'd1});
        ack_end = 1'b1; step(1); ack_end = 1'b0;
        chk("R8 release after ack", sw_en, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule